// File: doc/BRIEF.md
# Synchronous Serial Codec Port

This block is a full-duplex synchronous serial port. A transmit path takes parallel words from the host and sends them out on a serial line. A receive path collects serial bits and hands them to the host as parallel words. Bits move on a bit clock, and a frame sync marks where each word starts. Static configuration inputs set the word width, the frame sync polarity and the bit clock edge that launches and samples data.

The port runs in one of two roles. As master it divides the system clock down to make the bit clock and drives the frame sync itself. As slave it takes the bit clock and frame sync from outside. In slave mode it passes them, and the receive line, through two-flop synchronizers and finds their edges in the system clock domain. Every frame has the word width plus one bit slots. The frame sync is active during slot 0, which carries no data. The word follows, most significant bit first. The host side has a valid/ready transmit interface with a one-word holding register. On the receive side it sees a one-cycle valid pulse, and two flags report underrun and overrun.

Configuration may change only while rst_ni is low.

Top module: `sync_serial_port`

## Requirements
- R1: cfg_width_i selects the word width: code 0 = 8, 1 = 16, 2 = 24, 3 = 32 bits. Transmit uses the low width bits of tx_data_i. A received word sits in the low bits of rx_data_o, with the unused upper bits zero.
- R2: Data is sent and received most significant bit first.
- R3: With cfg_fs_low_i = 0 the frame sync is active high; with 1 it is active low. When inactive it rests at the opposite level, and that is its level during reset.
- R4: With cfg_edge_i = 0, data and frame sync change when the bit clock falls and are sampled when it rises. With cfg_edge_i = 1 the roles of the two edges swap. The idle (reset) level of bclk_o equals cfg_edge_i, so the first edge of bclk_o is always a sampling edge.
- R5: In master mode (cfg_master_i = 1), bclk_o toggles every cfg_div_i/2 system cycles; cfg_div_i must be even and at least 2. fs_o is active for exactly one bit period, and it changes only on edges of bclk_o. A frame lasts width+1 bit periods.
- R6: In slave mode, bclk_i, fs_i and rxd_i pass through two-flop synchronizers, and the port both receives and transmits on the external bit clock. Each bit clock half period must last at least 4 system cycles. bclk_o and fs_o hold their idle levels.
- R7: tx_ready_o is high while the one-word holding register is empty. A word is taken on a cycle with tx_valid_i and tx_ready_o both high, after which tx_ready_o is low until a frame start moves the word into the shifter.
- R8: If the holding register is empty when a frame starts, the frame carries all zero data and tx_underrun_o pulses high for one cycle.
- R9: rx_valid_o pulses for one cycle after the last bit of a word is sampled. In master mode it goes high (2*width+1)*cfg_div_i/2 system cycles after fs_o turns active.
- R10: A received word counts as taken once rx_ready_i is high during or after its valid pulse. If a new word completes while the previous one has not been taken, rx_overrun_o pulses together with rx_valid_o, and the new word replaces the old one.
- R11: During reset, tx_ready_o is 1 and rx_valid_o, txd_o, tx_underrun_o and rx_overrun_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_master_i | input | 1 | 1 = master, 0 = slave |
| cfg_width_i | input | 2 | Word width code |
| cfg_fs_low_i | input | 1 | 1 = frame sync active low |
| cfg_edge_i | input | 1 | Bit clock edge select |
| cfg_div_i | input | DIV_W | Master bit clock divisor |
| bclk_i | input | 1 | External bit clock (slave) |
| fs_i | input | 1 | External frame sync (slave) |
| rxd_i | input | 1 | Serial receive line |
| bclk_o | output | 1 | Generated bit clock (master) |
| fs_o | output | 1 | Generated frame sync (master) |
| txd_o | output | 1 | Serial transmit line |
| tx_data_i | input | DATA_W | Word to transmit |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Holding register empty |
| tx_underrun_o | output | 1 | Frame started with no word |
| rx_data_o | output | DATA_W | Last received word |
| rx_valid_o | output | 1 | One-cycle received-word strobe |
| rx_ready_i | input | 1 | Host takes the received word |
| rx_overrun_o | output | 1 | Previous word lost |

## Verification
All master timing is counted from the cycle in which fs_o turns active. The bit clock toggles after every cfg_div_i/2 cycles, the frame sync stays active for cfg_div_i cycles, and rx_valid_o is due exactly (2*width+1)*cfg_div_i/2 cycles later. The bench counts cycles at the falling edge of the system clock, checks rx_data_o in the cycle the valid pulse appears and confirms the pulse is gone one cycle later. In slave mode the bench drives the bit clock itself. It reads txd_o just before each rising bit clock edge it drives, which leaves room for the three-cycle synchronizer and edge-detect delay.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned CNT_W = 6;

  // width code -> bit count: 0..3 -> 8,16,24,32
  function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] code);
    logic [CNT_W-1:0] r;
    r = ({{(CNT_W-2){1'b0}}, code} + 6'd1) << 3;
    return r;
  endfunction
endpackage

// File: rtl/ssp_bclk_gen.sv
module ssp_bclk_gen #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] bits_i,
  output logic             ph_o,
  output logic             fs_o,
  output logic             sample_o,
  output logic             launch_o
);
  logic [DIV_W-2:0] cnt_q;
  logic [DIV_W-2:0] half;
  logic [CNT_W-1:0] slot_q, slot_nx;
  logic             ph_q, fs_q, tick;

  assign half    = div_i[DIV_W-1:1];
  assign tick    = en_i && (cnt_q == '0);
  // slots 0..bits; reset value all-ones wraps to slot 0 on first launch
  assign slot_nx = (slot_q >= bits_i) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      fs_q   <= 1'b0;
      slot_q <= '1;
    end else if (!en_i) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      fs_q   <= 1'b0;
      slot_q <= '1;
    end else if (tick) begin
      cnt_q <= half - 1'b1;
      ph_q  <= ~ph_q;
      if (ph_q) begin
        slot_q <= slot_nx;
        fs_q   <= (slot_nx == '0);
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ph_o     = ph_q;
  assign fs_o     = fs_q;
  assign sample_o = tick & ~ph_q;
  assign launch_o = tick & ph_q;
endmodule

// File: rtl/ssp_slave_front.sv
module ssp_slave_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic bclk_i,
  input  logic fs_i,
  input  logic rxd_i,
  output logic fs_o,
  output logic rxd_o,
  output logic sample_o,
  output logic launch_o
);
  logic [SYNC_STAGES-1:0][2:0] stg_q;
  logic ph, ph_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q     <= '0;
      ph_prev_q <= 1'b0;
    end else begin
      stg_q[0] <= {bclk_i, fs_i, rxd_i};
      for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
      ph_prev_q <= ph;
    end
  end

  assign ph       = stg_q[SYNC_STAGES-1][2] ^ edge_i;
  assign fs_o     = stg_q[SYNC_STAGES-1][1];
  assign rxd_o    = stg_q[SYNC_STAGES-1][0];
  assign sample_o = ph & ~ph_prev_q;
  assign launch_o = ~ph & ph_prev_q;
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  bits_i,
  input  logic              start_i,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              txd_o,
  output logic              underrun_o
);
  logic [DATA_W-1:0] hold_q, sh_q;
  logic [CNT_W-1:0]  cnt_q, shamt;
  logic              full_q, accept;

  assign accept     = tx_valid_i & ~full_q;
  assign tx_ready_o = ~full_q;
  assign shamt      = CNT_W'(DATA_W) - bits_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      full_q     <= 1'b0;
      sh_q       <= '0;
      cnt_q      <= '0;
      txd_o      <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      if (accept) hold_q <= tx_data_i;
      full_q     <= start_i ? accept : (full_q | accept);
      underrun_o <= start_i & ~full_q;
      if (start_i) begin
        cnt_q <= bits_i;
        sh_q  <= full_q ? (hold_q << shamt) : '0;  // left-align word
      end else if (launch_i) begin
        if (cnt_q != '0) begin
          txd_o <= sh_q[DATA_W-1];
          sh_q  <= sh_q << 1;
          cnt_q <= cnt_q - 1'b1;
        end else begin
          txd_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  bits_i,
  input  logic              start_i,
  input  logic              sample_i,
  input  logic              rxd_i,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              overrun_o
);
  logic [DATA_W-1:0] sh_q, sh_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic              pend_q, pend_nx, done;

  assign sh_nx   = {sh_q[DATA_W-2:0], rxd_i};
  assign done    = sample_i & ~start_i & (cnt_q == CNT_W'(1));
  assign pend_nx = (rx_valid_o | pend_q) & ~rx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      overrun_o  <= 1'b0;
    end else begin
      rx_valid_o <= done;
      overrun_o  <= done & pend_nx;
      pend_q     <= done ? 1'b0 : pend_nx;
      if (done) rx_data_o <= sh_nx;
      if (start_i) begin
        sh_q  <= '0;  // sync slot bit is dropped
        cnt_q <= bits_i;
      end else if (sample_i && cnt_q != '0) begin
        sh_q  <= sh_nx;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_master_i,
  input  logic [1:0]        cfg_width_i,
  input  logic              cfg_fs_low_i,
  input  logic              cfg_edge_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic              bclk_i,
  input  logic              fs_i,
  input  logic              rxd_i,
  output logic              bclk_o,
  output logic              fs_o,
  output logic              txd_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              tx_underrun_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              rx_overrun_o
);
  import ssp_pkg::*;

  logic [CNT_W-1:0] bits;
  logic m_ph, m_fs, m_sample, m_launch;
  logic s_fs, s_rxd, s_sample, s_launch;
  logic sample_ev, launch_ev, fs_act, rxd_eff, start;

  assign bits = word_bits(cfg_width_i);

  ssp_bclk_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_gen (
    .clk_i, .rst_ni, .en_i(cfg_master_i), .div_i(cfg_div_i), .bits_i(bits),
    .ph_o(m_ph), .fs_o(m_fs), .sample_o(m_sample), .launch_o(m_launch)
  );

  ssp_slave_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni, .edge_i(cfg_edge_i), .bclk_i, .fs_i, .rxd_i,
    .fs_o(s_fs), .rxd_o(s_rxd), .sample_o(s_sample), .launch_o(s_launch)
  );

  assign sample_ev = cfg_master_i ? m_sample : s_sample;
  assign launch_ev = cfg_master_i ? m_launch : s_launch;
  assign fs_act    = cfg_master_i ? m_fs : (s_fs ^ cfg_fs_low_i);
  assign rxd_eff   = cfg_master_i ? rxd_i : s_rxd;
  assign start     = sample_ev & fs_act;

  assign bclk_o = m_ph ^ cfg_edge_i;
  assign fs_o   = m_fs ^ cfg_fs_low_i;

  ssp_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
    .clk_i, .rst_ni, .bits_i(bits), .start_i(start), .launch_i(launch_ev),
    .tx_data_i, .tx_valid_i, .tx_ready_o, .txd_o, .underrun_o(tx_underrun_o)
  );

  ssp_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni, .bits_i(bits), .start_i(start), .sample_i(sample_ev),
    .rxd_i(rxd_eff), .rx_ready_i, .rx_data_o, .rx_valid_o, .overrun_o(rx_overrun_o)
  );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_master_i,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic tx_underrun_o,
  input logic rx_valid_o,
  input logic rx_overrun_o,
  input logic bclk_o,
  input logic fs_o
);
  AST_RX_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);  // R9
  AST_UNDERRUN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_underrun_o |=> !tx_underrun_o);  // R8
  AST_OVERRUN_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_overrun_o |-> rx_valid_o);  // R10
  AST_HOLD_FULL_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);  // R7
  AST_FS_ON_BCLK_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_master_i && (fs_o != $past(fs_o))) |-> (bclk_o != $past(bclk_o)));  // R5
  AST_SLAVE_BCLK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_master_i && !$past(cfg_master_i)) |-> $stable(bclk_o));  // R6
endmodule

bind sync_serial_port ssp_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_master_i(cfg_master_i),
  .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .tx_underrun_o(tx_underrun_o),
  .rx_valid_o(rx_valid_o), .rx_overrun_o(rx_overrun_o),
  .bclk_o(bclk_o), .fs_o(fs_o)
);

// File: tb/sim_sync_serial_port.sv
module sim_sync_serial_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_master_i = 1'b1;
  logic [1:0]  cfg_width_i = '0;
  logic        cfg_fs_low_i = 1'b0;
  logic        cfg_edge_i = 1'b0;
  logic [7:0]  cfg_div_i = 8'd2;
  logic        bclk_i = 1'b0, fs_i = 1'b0, rxd_i_ext = 1'b0;
  logic        bclk_o, fs_o, txd_o;
  logic [31:0] tx_data_i = '0;
  logic        tx_valid_i = 1'b0, tx_ready_o, tx_underrun_o;
  logic [31:0] rx_data_o;
  logic        rx_valid_o, rx_overrun_o;
  logic        rx_ready_i = 1'b1;
  logic        loop_en = 1'b1;
  logic        rxd_i;
  int          checks = 0, fails = 0;

  always #5 clk_i = ~clk_i;
  assign rxd_i = loop_en ? txd_o : rxd_i_ext;

  sync_serial_port u0 (
    .clk_i, .rst_ni, .cfg_master_i, .cfg_width_i, .cfg_fs_low_i, .cfg_edge_i,
    .cfg_div_i, .bclk_i, .fs_i, .rxd_i, .bclk_o, .fs_o, .txd_o,
    .tx_data_i, .tx_valid_i, .tx_ready_o, .tx_underrun_o,
    .rx_data_o, .rx_valid_o, .rx_ready_i, .rx_overrun_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {width code, fs_low, edge, div, data}
  localparam logic [43:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b0, 8'd2,  32'h0000_00A5},
    {2'd1, 1'b1, 1'b0, 8'd4,  32'h0000_C3E1},
    {2'd2, 1'b0, 1'b1, 8'd6,  32'h009A_5F17},
    {2'd3, 1'b1, 1'b1, 8'd2,  32'hDEAD_BEEF},
    {2'd0, 1'b1, 1'b1, 8'd8,  32'hFFFF_FF81},
    {2'd3, 1'b0, 1'b0, 8'd10, 32'h8000_0001}
  };

  task automatic reset_load(input logic [31:0] d, input bit load);
    rst_ni = 1'b0;
    tx_valid_i = load;
    tx_data_i = d;
    repeat (3) @(negedge clk_i);
    chk(tx_ready_o == 1'b1 && rx_valid_o == 1'b0 && txd_o == 1'b0 &&
        tx_underrun_o == 1'b0 && rx_overrun_o == 1'b0, "R11 reset outputs",
        {tx_ready_o, rx_valid_o, txd_o, tx_underrun_o, rx_overrun_o}, 32'h10);
    rst_ni = 1'b1;
    @(negedge clk_i);
    if (load) chk(tx_ready_o == 1'b0, "R7 holding full after accept", tx_ready_o, 0);
    tx_valid_i = 1'b0;
  endtask

  task automatic run_vec(input logic [43:0] v);
    int w, h, n, cnt, tog, fsc;
    bit ur;
    logic prev, fsl, edg;
    logic [31:0] exp;
    w   = (int'(v[43:42]) + 1) * 8;
    fsl = v[41];
    edg = v[40];
    h   = int'(v[39:32]) / 2;
    exp = (w == 32) ? v[31:0] : (v[31:0] & ((32'h1 << w) - 1));
    cfg_master_i = 1'b1; loop_en = 1'b1; rx_ready_i = 1'b1;
    cfg_width_i = v[43:42]; cfg_fs_low_i = fsl; cfg_edge_i = edg; cfg_div_i = v[39:32];
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(bclk_o == edg, "R4 idle bclk level", bclk_o, edg);
    chk(fs_o == fsl, "R3 idle fs level", fs_o, fsl);
    reset_load(v[31:0], 1'b1);
    n = 0;
    while (fs_o !== ~fsl && n < 5000) begin @(negedge clk_i); n++; end
    chk(bclk_o == edg, "R4 fs launched on launch edge", bclk_o, edg);
    cnt = 0; tog = 0; fsc = 1; prev = bclk_o; ur = 0;
    while (!rx_valid_o && cnt < 5000) begin
      @(negedge clk_i);
      cnt++;
      if (bclk_o != prev) tog++;
      prev = bclk_o;
      if (fs_o == ~fsl && fsc == cnt) fsc++;
      if (tx_underrun_o) ur = 1;
    end
    chk(rx_data_o == exp, "R1 loopback word", rx_data_o, exp);
    chk(cnt == (2 * w + 1) * h, "R9 rx latency", cnt, (2 * w + 1) * h);
    chk(tog == 2 * w + 1, "R5 bclk toggles", tog, 2 * w + 1);
    chk(fsc == 2 * h, "R5 fs width", fsc, 2 * h);
    chk(ur == 0, "R8 no underrun when loaded", ur, 0);
    @(negedge clk_i);
    chk(rx_valid_o == 1'b0, "R9 valid one cycle", rx_valid_o, 0);
  endtask

  task automatic slave_bit(input logic fsv, input logic d, output logic got, inout int vc);
    bclk_i = 1'b0; fs_i = fsv; rxd_i_ext = d;
    for (int k = 0; k < 8; k++) begin @(negedge clk_i); if (rx_valid_o) vc++; end
    got = txd_o;
    bclk_i = 1'b1;
    for (int k = 0; k < 8; k++) begin @(negedge clk_i); if (rx_valid_o) vc++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL R9 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] got;
    logic b;
    int vc;
    logic [15:0] sdat;

    foreach (VEC[i]) run_vec(VEC[i]);

    // underrun and overrun: width 8, div 2, host never takes words at first
    cfg_master_i = 1'b1; loop_en = 1'b1; rx_ready_i = 1'b0;
    cfg_width_i = 2'd0; cfg_fs_low_i = 1'b0; cfg_edge_i = 1'b0; cfg_div_i = 8'd2;
    reset_load(32'h3C, 1'b1);
    n = 0; while (!rx_valid_o && n < 500) begin @(negedge clk_i); n++; end
    chk(rx_data_o == 32'h3C, "R1 first word", rx_data_o, 32'h3C);
    chk(rx_overrun_o == 1'b0, "R10 no overrun on first word", rx_overrun_o, 0);
    n = 0; while (!tx_underrun_o && n < 500) begin @(negedge clk_i); n++; end
    chk(tx_underrun_o == 1'b1, "R8 underrun pulse", tx_underrun_o, 1);
    @(negedge clk_i);
    chk(tx_underrun_o == 1'b0, "R8 underrun one cycle", tx_underrun_o, 0);
    n = 0; while (!rx_valid_o && n < 500) begin @(negedge clk_i); n++; end
    chk(rx_data_o == 32'h0, "R8 zero data on underrun", rx_data_o, 0);
    chk(rx_overrun_o == 1'b1, "R10 overrun on untaken word", rx_overrun_o, 1);
    rx_ready_i = 1'b1;
    @(negedge clk_i);
    n = 0; while (!rx_valid_o && n < 500) begin @(negedge clk_i); n++; end
    chk(rx_valid_o == 1'b1 && rx_overrun_o == 1'b0, "R10 no overrun once taken",
        {rx_valid_o, rx_overrun_o}, 32'h2);

    // slave: width 16, fs active low, edge 0, half period 8 cycles
    cfg_master_i = 1'b0; loop_en = 1'b0; rx_ready_i = 1'b1;
    cfg_width_i = 2'd1; cfg_fs_low_i = 1'b1; cfg_edge_i = 1'b0;
    bclk_i = 1'b0; fs_i = 1'b1; rxd_i_ext = 1'b0;
    reset_load(32'h1234, 1'b1);
    repeat (4) @(negedge clk_i);
    sdat = 16'hB00F; vc = 0; got = '0;
    slave_bit(1'b0, 1'b0, b, vc);
    for (int i = 15; i >= 0; i--) begin
      slave_bit(1'b1, sdat[i], b, vc);
      got = {got[14:0], b};
    end
    slave_bit(1'b1, 1'b0, b, vc);
    slave_bit(1'b1, 1'b0, b, vc);
    chk(rx_data_o == 32'hB00F, "R6 R2 slave receive msb first", rx_data_o, 32'hB00F);
    chk(got == 16'h1234, "R6 R2 slave transmit msb first", got, 16'h1234);
    chk(vc == 1, "R9 slave single valid pulse", vc, 1);
    chk(bclk_o == 1'b0 && fs_o == 1'b1, "R6 slave outputs idle", {bclk_o, fs_o}, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule